// File: doc/BRIEF.md
# PHY Management Serial Master

This block is the management-side master of a two-wire PHY management link. It produces the management clock and shifts clause-22 frames out on the data line, so the host can read and write the registers of an external PHY. The block owns the clock and the timing of every bit.

The host works through one 32-bit command word. A single write places the PHY address, the register address and the write data, and chooses the operation with two request bits. Reading the word back returns the same fields, a busy flag, and a done flag that reports that a read result has arrived in the low half. The data line is modelled as three signals: an output, an output enable and an input.

A discovery sequencer, started by a one-cycle request, reads the identifier register (register 3) of every PHY address from 0 upwards. It stops at the first address whose reply is neither all ones nor all zeros. If no address replies with a valid value, it reports address 1 and a not-found flag.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset `mdc` is 0, `mdio_oe` is 0, `mdio_o` is 1, `cmd_rdata` is 0 and `scan_valid` is 0.
- R2: Command word layout. Bits 25:21 hold the PHY address, bits 20:16 the register address and bits 15:0 the data. Bit 26 requests a write and bit 27 requests a read. When read back, bit 29 is busy, bit 28 is read-done, and bits 31:30 and 27:26 return 0.
- R3: A write request sends the following frame, with `mdio_oe` high for every bit: PRE_LEN ones, start 0,1, opcode 0,1, the PHY address MSB first, the register address MSB first, turnaround 1,0, then the 16 data bits MSB first.
- R4: A read request sends PRE_LEN ones, 0,1, opcode 1,0, then the PHY address and the register address. It then drops `mdio_oe` for one turnaround bit and for 16 data bits, and captures those data bits MSB first. At the end of the frame the data appear in bits 15:0 and bit 28 goes to 1. If bits 26 and 27 are both set, the command is a read.
- R5: Each high phase and each low phase of `mdc` inside a frame lasts CLK_DIV clock cycles. `mdio_o` changes only while `mdc` is low. `mdio_i` is sampled when `mdc` rises.
- R6: Busy (bit 29) is 1 from the cycle after a frame or a scan is accepted until it ends. A command write made while busy is ignored: the fields do not change and no frame is sent.
- R7: A command write that is accepted clears bit 28 in the next cycle.
- R8: A scan reads register 3 at PHY addresses 0, 1, 2, … in that order. It stops at the first reply that is not 16'hFFFF and not 16'h0000. It then sets `scan_valid` and `scan_found` to 1 and `scan_addr` to that address.
- R9: If all 32 addresses reply 16'hFFFF or 16'h0000, the scan ends with `scan_valid` 1, `scan_found` 0 and `scan_addr` 1.
- R10: When no frame is in progress, `mdc` and `mdio_oe` are both held at 0.
- R11: An accepted command write with bits 26 and 27 both clear stores the three fields and sends no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word write value |
| cmd_rdata | output | 32 | Command word read value, including busy and done |
| scan_start | input | 1 | Starts a PHY discovery scan |
| scan_valid | output | 1 | Scan result is valid |
| scan_found | output | 1 | The scan found a responding PHY |
| scan_addr | output | 5 | Address found, or 1 if none was found |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The assertions check on every cycle the properties that hold at any moment:
- the data output never changes while the clock is high;
- the clock and the output enable rest low when idle, and the enable stays low from the read turnaround onwards;
- writes while busy leave the fields untouched, and an accepted write clears done;
- the engine is never restarted mid-frame;
- the scan result matches the reply that ended the scan.

Only the bench scenarios can show that a frame carries the right bits in the right order, because a PHY model decodes every frame against a queue of expected frames. The same holds for the preamble length, the order of addresses in a scan, and the choice of the first valid reply among all-ones and all-zeros replies.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int CMD_WR_BIT   = 26;
    localparam int CMD_RD_BIT   = 27;
    localparam int CMD_DONE_BIT = 28;
    localparam int CMD_BUSY_BIT = 29;
    localparam logic [4:0] ID_REG  = 5'd3;
    localparam logic [4:0] NO_PHY  = 5'd1;
    localparam logic [1:0] OP_WR   = 2'b01;
    localparam logic [1:0] OP_RD   = 2'b10;
    localparam logic [1:0] SOF     = 2'b01;
    localparam logic [1:0] TA_WR   = 2'b10;

    typedef struct packed {
        logic        rd;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mdio_req_t;

    typedef enum logic [1:0] {SC_IDLE, SC_ISSUE, SC_WAIT} scan_st_e;
endpackage

// File: rtl/mdio_tick.sv
module mdio_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] TOP = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == TOP);
        cnt_d = (!en || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int CLK_DIV = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  mdio_req_t   req,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    localparam int WR_LEN = PRE_LEN + 32;
    localparam int RD_LEN = PRE_LEN + 31;
    localparam int BW     = $clog2(WR_LEN);
    localparam logic [BW-1:0] WR_LAST  = BW'(WR_LEN - 1);
    localparam logic [BW-1:0] RD_LAST  = BW'(RD_LEN - 1);
    localparam logic [BW-1:0] PRE_END  = BW'(PRE_LEN);
    localparam logic [BW-1:0] TA_BIT   = BW'(PRE_LEN + 14);
    localparam logic [BW-1:0] SAMP_BIT = BW'(PRE_LEN + 15);

    typedef struct packed {
        logic          active;
        logic          rd;
        logic          mdc;
        logic          mdo;
        logic          oe;
        logic [BW-1:0] bitn;
        logic [31:0]   sh;
        logic [15:0]   rdata;
    } frm_t;

    frm_t s_d, s_q;
    logic tick;
    logic [BW-1:0] nb, last_bit;

    mdio_tick #(.DIV(CLK_DIV)) i_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (s_q.active),
        .tick (tick)
    );

    always_comb begin
        s_d      = s_q;
        done     = 1'b0;
        nb       = s_q.bitn + 1'b1;
        last_bit = s_q.rd ? RD_LAST : WR_LAST;
        if (!s_q.active) begin
            if (start) begin
                s_d.active = 1'b1;
                s_d.rd     = req.rd;
                s_d.mdc    = 1'b0;
                s_d.mdo    = 1'b1;
                s_d.oe     = 1'b1;
                s_d.bitn   = '0;
                s_d.rdata  = '0;
                s_d.sh     = {SOF, (req.rd ? OP_RD : OP_WR), req.phy,
                              req.regad, TA_WR, req.wdata};
            end
        end else if (tick) begin
            if (!s_q.mdc) begin
                s_d.mdc = 1'b1;
                if (s_q.rd && s_q.bitn >= SAMP_BIT)
                    s_d.rdata = {s_q.rdata[14:0], mdio_i};
            end else begin
                s_d.mdc = 1'b0;
                if (s_q.bitn == last_bit) begin
                    s_d.active = 1'b0;
                    s_d.oe     = 1'b0;
                    s_d.mdo    = 1'b1;
                    done       = 1'b1;
                end else begin
                    s_d.bitn = nb;
                    if (nb >= PRE_END) begin
                        s_d.mdo = s_q.sh[31];
                        s_d.sh  = {s_q.sh[30:0], 1'b0};
                    end
                    if (s_q.rd && nb >= TA_BIT)
                        s_d.oe = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{active: 1'b0, rd: 1'b0, mdc: 1'b0, mdo: 1'b1,
                             oe: 1'b0, bitn: '0, sh: '0, rdata: '0};
        else        s_q <= s_d;
    end

    assign busy    = s_q.active;
    assign rd_data = s_q.rdata;
    assign mdc     = s_q.mdc;
    assign mdio_o  = s_q.mdo;
    assign mdio_oe = s_q.oe;

    // R5: data edge only while clock low
    p_mdo_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(s_q.mdo) |-> !s_q.mdc);
    // R4: line released from read turnaround to frame end
    p_rd_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.active && s_q.rd && s_q.bitn >= TA_BIT) |-> !s_q.oe);
    // R10: idle line quiet
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.active |-> (!s_q.mdc && !s_q.oe));
endmodule

// File: rtl/mdio_scan.sv
module mdio_scan
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        go,
    input  logic        frame_done,
    input  logic [15:0] rd_data,
    output logic        issue,
    output logic [4:0]  issue_phy,
    output logic        busy,
    output logic        res_valid,
    output logic        res_found,
    output logic [4:0]  res_addr
);
    localparam logic [4:0] LAST_PHY = 5'd31;

    typedef struct packed {
        scan_st_e   st;
        logic [4:0] addr;
        logic       valid;
        logic       found;
        logic [4:0] res;
    } scan_t;

    scan_t s_d, s_q;
    logic reply_ok;

    always_comb begin
        s_d      = s_q;
        reply_ok = (rd_data != 16'hFFFF) && (rd_data != 16'h0000);
        case (s_q.st)
            SC_IDLE: if (go) begin
                s_d.st    = SC_ISSUE;
                s_d.addr  = '0;
                s_d.valid = 1'b0;
                s_d.found = 1'b0;
            end
            SC_ISSUE: s_d.st = SC_WAIT;
            SC_WAIT: if (frame_done) begin
                if (reply_ok) begin
                    s_d.st    = SC_IDLE;
                    s_d.valid = 1'b1;
                    s_d.found = 1'b1;
                    s_d.res   = s_q.addr;
                end else if (s_q.addr == LAST_PHY) begin
                    s_d.st    = SC_IDLE;
                    s_d.valid = 1'b1;
                    s_d.found = 1'b0;
                    s_d.res   = NO_PHY;
                end else begin
                    s_d.addr = s_q.addr + 1'b1;
                    s_d.st   = SC_ISSUE;
                end
            end
            default: s_d.st = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SC_IDLE, addr: '0, valid: 1'b0,
                             found: 1'b0, res: '0};
        else        s_q <= s_d;
    end

    assign issue     = (s_q.st == SC_ISSUE);
    assign issue_phy = s_q.addr;
    assign busy      = (s_q.st != SC_IDLE);
    assign res_valid = s_q.valid;
    assign res_found = s_q.found;
    assign res_addr  = s_q.res;

    // R9: exhausted scan falls back to the default address
    p_miss_default_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SC_WAIT && frame_done && s_q.addr == LAST_PHY &&
         (rd_data == 16'hFFFF || rd_data == 16'h0000))
        |=> (s_q.valid && !s_q.found && s_q.res == NO_PHY));
    // R8: a valid reply ends the scan at the current address
    p_hit_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == SC_WAIT && frame_done && rd_data != 16'hFFFF &&
         rd_data != 16'h0000)
        |=> (s_q.valid && s_q.found && s_q.res == $past(s_q.addr)));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
    import mdio_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int PRE_LEN = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_we,
    input  logic [31:0] cmd_wdata,
    output logic [31:0] cmd_rdata,
    input  logic        scan_start,
    output logic        scan_valid,
    output logic        scan_found,
    output logic [4:0]  scan_addr,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] data;
        logic        done;
        logic        rd_pend;
    } ctl_t;

    ctl_t c_d, c_q;
    logic eng_busy, eng_done, eng_start;
    logic [15:0] eng_rdata;
    mdio_req_t eng_req;
    logic scan_busy, scan_issue;
    logic [4:0] scan_phy;
    logic busy, cmd_acc, cmd_go, scan_go;
    logic unused_hi;

    assign unused_hi = ^cmd_wdata[31:28];

    always_comb begin
        busy    = eng_busy | scan_busy;
        cmd_acc = cmd_we && !busy;
        cmd_go  = cmd_acc && (cmd_wdata[CMD_WR_BIT] || cmd_wdata[CMD_RD_BIT]);
        scan_go = scan_start && !busy && !cmd_acc;
        eng_start = cmd_go || scan_issue;
        if (scan_issue)
            eng_req = '{rd: 1'b1, phy: scan_phy, regad: ID_REG, wdata: 16'h0};
        else
            eng_req = '{rd: cmd_wdata[CMD_RD_BIT], phy: cmd_wdata[25:21],
                        regad: cmd_wdata[20:16], wdata: cmd_wdata[15:0]};

        c_d = c_q;
        if (cmd_acc) begin
            c_d.phy     = cmd_wdata[25:21];
            c_d.regad   = cmd_wdata[20:16];
            c_d.data    = cmd_wdata[15:0];
            c_d.done    = 1'b0;
            c_d.rd_pend = cmd_wdata[CMD_RD_BIT];
        end else if (eng_done && !scan_busy && c_q.rd_pend) begin
            c_d.data    = eng_rdata;
            c_d.done    = 1'b1;
            c_d.rd_pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    mdio_frame #(.PRE_LEN(PRE_LEN), .CLK_DIV(CLK_DIV)) i_frame (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (eng_start),
        .req    (eng_req),
        .busy   (eng_busy),
        .done   (eng_done),
        .rd_data(eng_rdata),
        .mdc    (mdc),
        .mdio_o (mdio_o),
        .mdio_oe(mdio_oe),
        .mdio_i (mdio_i)
    );

    mdio_scan i_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (scan_go),
        .frame_done(eng_done),
        .rd_data   (eng_rdata),
        .issue     (scan_issue),
        .issue_phy (scan_phy),
        .busy      (scan_busy),
        .res_valid (scan_valid),
        .res_found (scan_found),
        .res_addr  (scan_addr)
    );

    assign cmd_rdata = {2'b00, busy, c_q.done, 2'b00, c_q.phy, c_q.regad, c_q.data};

    // R6: fields frozen against writes while busy
    p_busy_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_we) |=> ($stable(c_q.phy) && $stable(c_q.regad)));
    // R6: engine never restarted mid-frame
    p_no_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |-> !eng_start);
    // R7: accepted write clears done
    p_done_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy) |=> !c_q.done);
endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
    localparam int CLK_DIV = 2;
    localparam int PRE_LEN = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_we = 1'b0;
    logic [31:0] cmd_wdata = '0;
    logic [31:0] cmd_rdata;
    logic scan_start = 1'b0;
    logic scan_valid, scan_found;
    logic [4:0] scan_addr;
    logic mdc, mdio_o, mdio_oe;
    logic mdio_i = 1'b1;

    always #2 clk = ~clk;

    mdio_mgmt_ctrl #(.CLK_DIV(CLK_DIV), .PRE_LEN(PRE_LEN)) i_mdio_mgmt_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .cmd_rdata(cmd_rdata), .scan_start(scan_start), .scan_valid(scan_valid),
        .scan_found(scan_found), .scan_addr(scan_addr), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    typedef struct {
        bit       rd;
        bit [4:0] phy;
        bit [4:0] rg;
        bit [15:0] dat;
    } frm_t;

    frm_t exp_q[$];
    int n_chk = 0, n_bad = 0, n_frames = 0;
    int hp_bad = 0, edge_bad = 0, run_len = 0;
    logic prev_mdc = 1'b0, prev_mdo = 1'b1;
    logic [15:0] id3 [32];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] phy_val(input logic [4:0] a, input logic [4:0] r);
        if (r == 5'd3) return id3[a];
        return {1'b1, a, r, 5'h0B};
    endfunction

    // R5 timing watch, sampled away from the active edge
    always @(negedge clk) begin
        if (mdc != prev_mdc) begin
            if (prev_mdc && run_len != CLK_DIV) hp_bad++;
            run_len = 1;
        end else run_len++;
        if (mdio_o != prev_mdo && mdc) edge_bad++;
        prev_mdc = mdc;
        prev_mdo = mdio_o;
    end

    task automatic get_bits(input int n, output logic [15:0] v);
        v = '0;
        repeat (n) begin
            @(posedge mdc);
            v = {v[14:0], mdio_o};
        end
    endtask

    // PHY model and scoreboard monitor
    initial begin
        forever begin
            int ones;
            int oe_bad;
            logic [15:0] st, op, pa, ra, ta, dv, rv;
            frm_t e;
            ones = 0;
            forever begin
                @(posedge mdc);
                if (mdio_o) ones++;
                else break;
            end
            get_bits(1, st);
            get_bits(2, op);
            get_bits(5, pa);
            get_bits(5, ra);
            n_frames++;
            chk(ones == PRE_LEN, "R3 preamble length", ones, PRE_LEN);
            chk(st[0] == 1'b1, "R3 start bits", st, 1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 unexpected frame", {op[1:0], pa[4:0], ra[4:0]}, 0);
                e = '{rd: 1'b0, phy: 5'd0, rg: 5'd0, dat: 16'd0};
            end else e = exp_q.pop_front();
            chk(op[1:0] == (e.rd ? 2'b10 : 2'b01), "R3 R4 opcode", op, e.rd ? 2 : 1);
            chk(pa[4:0] == e.phy, "R3 R4 phy address", pa, e.phy);
            chk(ra[4:0] == e.rg, "R3 R4 register address", ra, e.rg);
            if (op[1:0] == 2'b10) begin
                oe_bad = 0;
                rv = phy_val(pa[4:0], ra[4:0]);
                @(negedge mdc) mdio_i = 1'b0;
                @(posedge mdc) if (mdio_oe) oe_bad++;
                for (int i = 15; i >= 0; i--) begin
                    @(negedge mdc) mdio_i = rv[i];
                    @(posedge mdc) if (mdio_oe) oe_bad++;
                end
                @(negedge mdc) mdio_i = 1'b1;
                chk(oe_bad == 0, "R4 line released in read", oe_bad, 0);
            end else begin
                get_bits(2, ta);
                get_bits(16, dv);
                chk(ta[1:0] == 2'b10, "R3 write turnaround", ta, 2);
                chk(dv == e.dat, "R3 write data", dv, e.dat);
            end
        end
    end

    task automatic cmd_write(input logic [31:0] w);
        @(negedge clk);
        cmd_we = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we = 1'b0;
    endtask

    task automatic issue(input bit rd, input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] dat);
        exp_q.push_back('{rd: rd, phy: phy, rg: rg, dat: dat});
        cmd_write({4'b0000, rd, ~rd, phy, rg, dat});
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (cmd_rdata[29]) @(negedge clk);
    endtask

    task automatic run_scan(input int last_addr);
        for (int a = 0; a <= last_addr; a++)
            exp_q.push_back('{rd: 1'b1, phy: 5'(a), rg: 5'd3, dat: 16'h0});
        @(negedge clk);
        scan_start = 1'b1;
        @(negedge clk);
        scan_start = 1'b0;
        @(negedge clk);
        while (!scan_valid) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int f0;
        for (int a = 0; a < 32; a++) id3[a] = 16'hFFFF;
        repeat (5) @(negedge clk);
        // R1 reset state
        chk(cmd_rdata == 32'h0, "R1 command word", cmd_rdata, 0);
        chk(mdc == 1'b0 && mdio_oe == 1'b0 && mdio_o == 1'b1, "R1 line state",
            {mdc, mdio_oe, mdio_o}, 3'b001);
        chk(scan_valid == 1'b0, "R1 scan_valid", scan_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R3 write frame, R2 fields read back
        issue(1'b0, 5'd5, 5'd0, 16'hA5C3);
        chk(cmd_rdata[29] == 1'b1, "R6 busy during write", cmd_rdata[29], 1);
        wait_idle();
        chk(cmd_rdata == {6'b0, 5'd5, 5'd0, 16'hA5C3}, "R2 readback after write",
            cmd_rdata, {6'b0, 5'd5, 5'd0, 16'hA5C3});
        issue(1'b0, 5'd31, 5'd31, 16'h0001);
        wait_idle();

        // R4 read frame
        issue(1'b1, 5'd9, 5'd2, 16'h1234);
        wait_idle();
        chk(cmd_rdata[28] == 1'b1, "R4 done set", cmd_rdata[28], 1);
        chk(cmd_rdata[15:0] == phy_val(5'd9, 5'd2), "R4 read data",
            cmd_rdata[15:0], phy_val(5'd9, 5'd2));
        chk(cmd_rdata[25:16] == {5'd9, 5'd2}, "R2 fields after read",
            cmd_rdata[25:16], {5'd9, 5'd2});

        // R7 done clears on a new accepted command
        issue(1'b0, 5'd1, 5'd4, 16'h00FF);
        chk(cmd_rdata[28] == 1'b0, "R7 done cleared", cmd_rdata[28], 0);
        wait_idle();

        // R4 both request bits: read wins
        exp_q.push_back('{rd: 1'b1, phy: 5'd17, rg: 5'd30, dat: 16'h0});
        cmd_write({4'b0000, 2'b11, 5'd17, 5'd30, 16'h5555});
        wait_idle();
        chk(cmd_rdata[28] == 1'b1 && cmd_rdata[15:0] == phy_val(5'd17, 5'd30),
            "R4 read priority", cmd_rdata[15:0], phy_val(5'd17, 5'd30));

        // R6 write while busy is ignored
        issue(1'b1, 5'd12, 5'd6, 16'h0);
        repeat (40) @(negedge clk);
        chk(cmd_rdata[29] == 1'b1, "R6 busy mid read", cmd_rdata[29], 1);
        cmd_write({4'b0000, 2'b01, 5'd3, 5'd7, 16'hDEAD});
        wait_idle();
        f0 = n_frames;
        repeat (400) @(negedge clk);
        chk(cmd_rdata[25:16] == {5'd12, 5'd6}, "R6 fields unchanged",
            cmd_rdata[25:16], {5'd12, 5'd6});
        chk(cmd_rdata[15:0] == phy_val(5'd12, 5'd6), "R6 data is read result",
            cmd_rdata[15:0], phy_val(5'd12, 5'd6));
        chk(n_frames == f0 && exp_q.size() == 0, "R6 no extra frame", n_frames, f0);

        // R11 no request bit: fields stored, no frame; R10 idle line
        begin
            int idle_bad;
            idle_bad = 0;
            cmd_write({4'b0000, 2'b00, 5'd21, 5'd11, 16'hBEEF});
            repeat (300) begin
                @(negedge clk);
                if (mdc || mdio_oe) idle_bad++;
            end
            chk(idle_bad == 0, "R10 idle quiet", idle_bad, 0);
            chk(n_frames == f0, "R11 no frame", n_frames, f0);
            chk(cmd_rdata == {6'b0, 5'd21, 5'd11, 16'hBEEF}, "R11 fields stored",
                cmd_rdata, {6'b0, 5'd21, 5'd11, 16'hBEEF});
        end

        // R8 scan: all-ones and all-zeros replies are skipped
        id3[1] = 16'h0000; id3[3] = 16'h0000;
        id3[5] = 16'h0022; id3[6] = 16'h0033;
        run_scan(5);
        chk(scan_found == 1'b1 && scan_addr == 5'd5, "R8 first valid address",
            {scan_found, scan_addr}, {1'b1, 5'd5});
        chk(exp_q.size() == 0, "R8 scan order complete", exp_q.size(), 0);

        // R8 boundary: address 0 answers
        id3[0] = 16'h0141;
        run_scan(0);
        chk(scan_found == 1'b1 && scan_addr == 5'd0, "R8 address 0",
            {scan_found, scan_addr}, {1'b1, 5'd0});

        // R9 nobody answers; R6 command during scan ignored
        for (int a = 0; a < 32; a++) id3[a] = (a % 2) ? 16'h0000 : 16'hFFFF;
        for (int a = 0; a < 32; a++)
            exp_q.push_back('{rd: 1'b1, phy: 5'(a), rg: 5'd3, dat: 16'h0});
        @(negedge clk); scan_start = 1'b1;
        @(negedge clk); scan_start = 1'b0;
        repeat (100) @(negedge clk);
        cmd_write({4'b0000, 2'b10, 5'd2, 5'd2, 16'h0});
        @(negedge clk);
        while (!scan_valid) @(negedge clk);
        chk(scan_found == 1'b0 && scan_addr == 5'd1, "R9 default address",
            {scan_found, scan_addr}, {1'b0, 5'd1});
        chk(exp_q.size() == 0, "R9 all 32 addresses read", exp_q.size(), 0);
        chk(cmd_rdata[25:16] == {5'd21, 5'd11}, "R6 ignored during scan",
            cmd_rdata[25:16], {5'd21, 5'd11});

        // R8 boundary: only address 31 answers
        id3[31] = 16'h7777;
        run_scan(31);
        chk(scan_found == 1'b1 && scan_addr == 5'd31, "R8 address 31",
            {scan_found, scan_addr}, {1'b1, 5'd31});

        repeat (20) @(negedge clk);
        chk(hp_bad == 0, "R5 clock high phase length", hp_bad, 0);
        chk(edge_bad == 0, "R5 data change while clock high", edge_bad, 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule